// File: doc/BRIEF.md
# CRC-64 Signature Unit

This block keeps a 64-bit running signature over a stream of register writes. Every accepted write, whatever its size, is widened into one 64-bit chunk. The chunk is folded into the signature by a single CRC step per clock. The generator polynomial is fixed at x^64 + x^4 + x^3 + x + 1, which is 0x000000000000001B with the top term implied. The signature starts at zero. No bit reflection is applied on input or output, and no final XOR is applied.

Software or a transfer engine can feed the unit bytes, 32-bit words or whole doublewords. Byte lanes are chosen by a 3-bit byte address with big-endian numbering inside each 32-bit word. The lower word of the chunk sits at byte addresses 0..3 and the upper word at 4..7. Lanes that the write does not cover are zero in the chunk, so a stream of single bytes all sent to the least significant lane gives one CRC step per byte. A synchronous clear strobe returns the signature to zero. The signature is always visible on a read port.

Top module: `crc64_sig_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sig` reads zero until the first accepted write.
- R2: A step computes the new signature as the MSB-first CRC of (old signature XOR chunk) over 64 bits, using polynomial 0x1B, with no reflection and no final XOR. From a zero signature, the chunk 0x00000000075BCD15 gives 0x00000000468EEEC7.
- R3: Each write with `wr_en` high and a valid size advances the signature by exactly one step. The new value is on `sig` after the clock edge that samples the write, and not before.
- R4: Size code 2'b00 (byte) takes `wr_data[7:0]`. Byte addresses 0, 1, 2 and 3 place it at chunk bits 31:24, 23:16, 15:8 and 7:0. Byte addresses 4, 5, 6 and 7 place it at bits 63:56, 55:48, 47:40 and 39:32. All other bits of the chunk are zero.
- R5: Size code 2'b01 (word) takes `wr_data[31:0]`. When `wr_addr[2]` is 0 it goes to chunk bits 31:0, and when it is 1 it goes to bits 63:32. The other half of the chunk is zero, and `wr_addr[1:0]` has no effect.
- R6: Size code 2'b10 (doubleword) uses all of `wr_data` as the chunk with no padding. `wr_addr` has no effect.
- R7: Size code 2'b11 is reserved. A write with that code leaves `sig` unchanged.
- R8: `clr` high clears `sig` to zero at the next edge. When a write arrives in the same cycle, the clear wins and the write is dropped.
- R9: With neither `wr_en` nor `clr` high, `sig` holds its value.
- R10: Bits of `wr_data` above the width selected by the size code have no effect on the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous signature clear strobe |
| wr_en | input | 1 | Write strobe, one step per cycle in which it is high |
| wr_addr | input | 3 | Byte address inside the 64-bit input window |
| wr_size | input | 2 | 00 byte, 01 word, 10 doubleword, 11 reserved |
| wr_data | input | 64 | Write data, right-aligned for narrow sizes |
| sig | output | 64 | Current signature |

## Verification
The hardest case to reach is one where the byte lane and the padding differ from the obvious layout. A value can be correct but land in the wrong lane, or stray upper data bits can leak into the chunk. Both cases still yield a plausible signature, which only a second model can tell apart. The stimulus table walks one byte through all eight addresses and drives junk in the upper data bits of every narrow write. It also uses word writes with non-zero low address bits and a doubleword with a non-zero address. After each write the signature is compared against a bit-serial model that builds the chunk from the lane rules alone. A clear in the same cycle as a write, and an asynchronous reset in the middle of the stream, are driven as directed cases.

// File: rtl/crc64_pkg.sv
package crc64_pkg;

  localparam int unsigned CHUNK_W = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = $clog2(CHUNK_W / BYTE_W);

  localparam logic [CHUNK_W-1:0] CRC_POLY = 64'h0000_0000_0000_001B;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } wr_size_e;

endpackage

// File: rtl/crc64_rst_sync.sv
module crc64_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/crc64_lane_pack.sv
module crc64_lane_pack
  import crc64_pkg::*;
#(
  parameter int unsigned W     = CHUNK_W,
  parameter int unsigned BW    = BYTE_W,
  parameter int unsigned AW    = ADDR_W,
  localparam int unsigned LANES = W / BW,
  localparam int unsigned HALF  = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [W-1:0]  data,
  output logic          step,
  output logic [W-1:0]  chunk
);

  wr_size_e            size_e;
  logic [LANES-1:0]    lane_mask;
  logic [W-1:0]        placed;
  logic [W-1:0]        bit_mask;
  logic [AW-1:0]       byte_lane;

  assign size_e = wr_size_e'(size);

  // big-endian inside each half: lower address bits count down from the top lane
  assign byte_lane = {addr[AW-1], ~addr[AW-2:0]};

  always_comb begin
    lane_mask = '0;
    placed    = data;
    unique case (size_e)
      SZ_BYTE: begin
        lane_mask = LANES'(1) << byte_lane;
        placed    = {LANES{data[BW-1:0]}};
      end
      SZ_WORD: begin
        lane_mask = addr[AW-1] ? {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}}
                               : {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};
        placed    = {2{data[HALF-1:0]}};
      end
      SZ_DWORD: begin
        lane_mask = '1;
        placed    = data;
      end
      default: begin
        lane_mask = '0;
        placed    = data;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_mask[g*BW +: BW] = {BW{lane_mask[g]}};
  end

  assign chunk = placed & bit_mask;
  assign step  = en && (size_e != SZ_RSVD);

  // R4: a byte write opens exactly one lane
  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (en && size_e == SZ_BYTE) |-> ($countones(lane_mask) == 1));

  // R5: a word write opens exactly one half
  a_r5_word_half: assert property (@(posedge clk) disable iff (!rst_n)
    (en && size_e == SZ_WORD) |-> ($countones(lane_mask) == LANES/2));

  // R6: a doubleword passes through unpadded
  a_r6_dword_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (en && size_e == SZ_DWORD) |-> (chunk == data));

endmodule

// File: rtl/crc64_step.sv
module crc64_step #(
  parameter int unsigned   W    = 64,
  parameter logic [W-1:0]  POLY = 64'h1B
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] chunk,
  output logic [W-1:0] next
);

  always_comb begin
    logic [W-1:0] acc;
    acc = state ^ chunk;
    for (int i = 0; i < W; i++) begin
      acc = acc[W-1] ? ((acc << 1) ^ POLY) : (acc << 1);
    end
    next = acc;
  end

endmodule

// File: rtl/crc64_sig_reg.sv
module crc64_sig_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;
  logic         q_en;

  always_comb begin
    q_en   = clr || load;
    q_next = clr ? '0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_next;
  end

  // R8: a clear strobe always leaves zero behind
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  // R9: nothing requested, nothing moves
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(q));

endmodule

// File: rtl/crc64_sig_unit.sv
module crc64_sig_unit
  import crc64_pkg::*;
#(
  parameter int unsigned           W    = CHUNK_W,
  parameter logic [CHUNK_W-1:0]    POLY = CRC_POLY,
  localparam int unsigned          AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_size,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  sig
);

  logic         rst_sync_n;
  logic         step;
  logic [W-1:0] chunk;
  logic [W-1:0] sig_next;

  crc64_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crc64_lane_pack #(.W(W), .BW(BYTE_W), .AW(AW)) u_pack (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (wr_en),
    .addr  (wr_addr),
    .size  (wr_size),
    .data  (wr_data),
    .step  (step),
    .chunk (chunk)
  );

  crc64_step #(.W(W), .POLY(POLY)) u_step (
    .state (sig),
    .chunk (chunk),
    .next  (sig_next)
  );

  crc64_sig_reg #(.W(W)) u_sig (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .load  (step),
    .d     (sig_next),
    .q     (sig)
  );

  // R7: reserved size code never moves the signature
  a_r7_reserved_no_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_size == 2'b11 && !clr) |=> $stable(sig));

  // R1: signature is zero while reset is being released
  a_r1_reset_zero: assert property (@(posedge clk)
    (!rst_sync_n) |-> (sig == '0));

endmodule

// File: tb/crc64_sig_unit_tb.sv
module crc64_sig_unit_tb;

  localparam logic [63:0] POLY = 64'h1B;
  localparam int NV = 20;

  // vector: [70] clr, [69] wr_en, [68:66] addr, [65:64] size, [63:0] data
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd0, 2'b10, 64'h0000_0000_075B_CD15},
    {1'b0, 1'b1, 3'd0, 2'b00, 64'hDEAD_BEEF_CAFE_0011},
    {1'b0, 1'b1, 3'd1, 2'b00, 64'hDEAD_BEEF_CAFE_0022},
    {1'b0, 1'b1, 3'd2, 2'b00, 64'hDEAD_BEEF_CAFE_0033},
    {1'b0, 1'b1, 3'd3, 2'b00, 64'hDEAD_BEEF_CAFE_0044},
    {1'b0, 1'b1, 3'd4, 2'b00, 64'hFFFF_FFFF_FFFF_FF55},
    {1'b0, 1'b1, 3'd5, 2'b00, 64'h1234_5678_9ABC_DE66},
    {1'b0, 1'b1, 3'd6, 2'b00, 64'h8000_0000_0000_0177},
    {1'b0, 1'b1, 3'd7, 2'b00, 64'h0F0F_0F0F_0F0F_0F88},
    {1'b0, 1'b1, 3'd0, 2'b01, 64'hAAAA_BBBB_1234_5678},
    {1'b0, 1'b1, 3'd4, 2'b01, 64'h5555_6666_89AB_CDEF},
    {1'b0, 1'b1, 3'd6, 2'b01, 64'h0000_0001_0102_0304},
    {1'b0, 1'b1, 3'd3, 2'b01, 64'hFFFF_0000_F0E1_D2C3},
    {1'b0, 1'b1, 3'd5, 2'b10, 64'h0102_0304_0506_0708},
    {1'b0, 1'b1, 3'd0, 2'b11, 64'h0102_0304_0506_0708},
    {1'b0, 1'b0, 3'd0, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 1'b1, 3'd0, 2'b10, 64'h0000_0000_075B_CD15},
    {1'b0, 1'b1, 3'd0, 2'b10, 64'h0000_0000_075B_CD15},
    {1'b0, 1'b1, 3'd0, 2'b10, 64'h0102_0304_0506_0708},
    {1'b1, 1'b0, 3'd0, 2'b00, 64'h0}
  };

  localparam string VTAG [NV] = '{
    "R2", "R4", "R4", "R4", "R4", "R4", "R4", "R4", "R4",
    "R5", "R5", "R5", "R5", "R6", "R7", "R9", "R8", "R2", "R3", "R8"
  };

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [1:0]  wr_size;
  logic [63:0] wr_data;
  logic [63:0] sig;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model;

  crc64_sig_unit u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_size (wr_size),
    .wr_data (wr_data),
    .sig     (sig)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] ref_chunk(input logic [2:0] a, input logic [1:0] s,
                                            input logic [63:0] d);
    int pos;
    case (s)
      2'b00: begin
        pos = (a < 4) ? (3 - int'(a)) * 8 : 32 + (7 - int'(a)) * 8;
        return {56'h0, d[7:0]} << pos;
      end
      2'b01:   return a[2] ? {d[31:0], 32'h0} : {32'h0, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] ref_crc(input logic [63:0] crc, input logic [63:0] c);
    logic fb;
    for (int i = 63; i >= 0; i--) begin
      fb  = crc[63] ^ c[i];
      crc = crc << 1;
      if (fb) crc = crc ^ POLY;
    end
    return crc;
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (sig !== exp) begin
      fails++;
      $display("FAIL %s: sig=%h expected=%h", req, sig, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // called at a negedge; returns at the following negedge with inputs idle
  task automatic apply(input logic c, input logic e, input logic [2:0] a,
                       input logic [1:0] s, input logic [63:0] d, input string req);
    clr = c; wr_en = e; wr_addr = a; wr_size = s; wr_data = d;
    @(negedge clk);
    if (c)                      model = '0;
    else if (e && s != 2'b11)   model = ref_crc(model, ref_chunk(a, s, d));
    check(req, model);
    clr = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R3: watchdog expired sig=%h expected=%h", sig, model);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_size = '0; wr_data = '0;
    model = '0;
    repeat (3) @(negedge clk);
    check("R1", 64'h0);                       // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 64'h0);                       // R1 after release

    // R2 literal value from a zero signature
    apply(1'b0, 1'b1, 3'd0, 2'b10, 64'h0000_0000_075B_CD15, "R2");
    check("R2", 64'h0000_0000_468E_EEC7);
    apply(1'b1, 1'b0, 3'd0, 2'b00, 64'h0, "R8");

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][70], VEC[i][69], VEC[i][68:66], VEC[i][65:64], VEC[i][63:0], VTAG[i]);
    end

    // R3: write not visible before its sampling edge
    apply(1'b0, 1'b1, 3'd3, 2'b00, 64'h5A, "R3");
    clr = 1'b0; wr_en = 1'b1; wr_addr = 3'd3; wr_size = 2'b00; wr_data = 64'hA5;
    #1;
    check("R3", model);
    @(negedge clk);
    model = ref_crc(model, 64'hA5);
    check("R3", model);
    wr_en = 1'b0;

    // R4: ASCII byte stream, low lane, one step per byte
    apply(1'b1, 1'b0, 3'd0, 2'b00, 64'h0, "R8");
    for (int b = 0; b < 9; b++) begin
      apply(1'b0, 1'b1, 3'd3, 2'b00, 64'(8'h31 + b), "R4");
    end

    // R10: junk upper bits give the same result as clean data
    apply(1'b1, 1'b0, 3'd0, 2'b00, 64'h0, "R8");
    apply(1'b0, 1'b1, 3'd1, 2'b01, 64'hFFFF_FFFF_0000_00C3, "R10");
    check("R10", ref_crc(64'h0, 64'h0000_0000_0000_00C3));

    // R1: asynchronous reset in mid-stream
    apply(1'b0, 1'b1, 3'd7, 2'b00, 64'h99, "R4");
    #1 rst_n = 1'b0;
    #1 check("R1", 64'h0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 64'h0);
    apply(1'b0, 1'b1, 3'd0, 2'b10, 64'h0000_0000_075B_CD15, "R2");
    check("R2", 64'h0000_0000_468E_EEC7);

    finish_run();
  end

endmodule